// File: doc/BRIEF.md
# Programmable Interval Timer Counter

This block is one 16-bit binary down-counter for timing and event work. A host writes it one byte at a time. A control byte picks the byte-access scheme and one of six waveform modes. Data bytes then supply the initial count. The counter moves only on system-clock cycles in which the counting strobe `tick_i` is high. A gate input enables, pauses or triggers counting, depending on the mode, and the block drives a single output line `out_o`.

The host can read the counting element on `count_o` at any time. It can also read a status byte that shows the output level, a flag that is set while a freshly written count is still waiting to enter the counting element, and the programmed control fields. A count of zero stands for 65536. While the low byte of a two-byte count is written and the high byte is still missing, counting is frozen.

Top module: `pit_counter`

## Requirements
- R1: After reset, `out_o` is 0, `count_o` is 0 and `status_o` is 0x40 (pending-count flag set, all control fields zero).
- R2: A control byte (`wr_ctrl_i`=1) carries select[7:6], access[5:4], mode[3:1] and bcd[0]. It is dropped when select differs from parameter SLOT or when access is 00. Otherwise it stores the fields, stops counting, sets the pending-count flag and sets `out_o` low for mode 0 and high for every other mode. Mode codes 110 and 111 behave as modes 2 and 3.
- R3: Count bytes (`wr_ctrl_i`=0) fill the count according to access. Access 01 loads the low byte and clears the high byte. Access 10 loads the high byte and clears the low byte. Access 11 takes the low byte and then the high byte. Between those two writes, strobes do not change the counting element.
- R4: The pending-count flag (status bit 6) becomes 1 after a complete count write and stays 1 until that count is moved into the counting element.
- R5: `status_o` = {out level, pending flag, access[1:0], mode code[2:0], bcd}, with fields as written. `count_o` is the counting element. Counting is always binary.
- R6: Mode 0: the first strobe after the count write loads N with `out_o` low. Each later strobe with the gate high decrements the count. `out_o` rises on the strobe that makes the count 0 and stays high.
- R7: Mode 1: a gate rising edge, taken at the next strobe, loads N and drives `out_o` low. `out_o` returns high after N strobes. A new gate rising edge reloads N.
- R8: Mode 2: the count starts on the strobe after the write (or after a gate rising edge). `out_o` is low for one strobe in every N strobes, and the count then reloads automatically.
- R9: Mode 3: `out_o` is a square wave with (N+1)/2 strobes high and N/2 strobes low (integer division), so an odd N gives a high phase one strobe longer.
- R10: Mode 4: after loading N on the first strobe, `out_o` stays high, falls for exactly one strobe when the count reaches 0, and does not pulse again until a new count is written.
- R11: Mode 5: like mode 4, but the load happens only on a gate rising edge, which also re-arms the one-shot.
- R12: A low gate holds the count in modes 0, 2, 3 and 4. In modes 2 and 3 it also drives `out_o` high one clock after the gate falls. The next gate rising edge reloads the count in modes 2 and 3.
- R13: A count of 0 behaves as 65536: in mode 0, `out_o` rises 65536 strobes after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Counting strobe, one count step per high cycle |
| gate_i | input | 1 | Gate level, synchronous to clk |
| wr_i | input | 1 | Host byte write |
| wr_ctrl_i | input | 1 | 1: control byte, 0: count byte |
| wr_data_i | input | BYTE_W | Write data |
| out_o | output | 1 | Counter output line |
| count_o | output | 2*BYTE_W | Counting element read-back |
| status_o | output | BYTE_W | Status byte |

## Verification
The bench drives random counts and random gaps between strobes. It measures how long each phase of `out_o` lasts in strobes, so that an off-by-one in a reload, as well as square-wave phases that come out equal for odd counts, show up as run lengths that are one strobe off. Directed cases cover the following:
- Writing only the low byte of a two-byte count: a design that keeps counting moves `count_o`.
- The pending flag after a write and after the load strobe.
- Dropping the gate while the output is low in modes 2 and 3: a design that only forces the output high on a later strobe leaves `out_o` low.
- Select and access fields that must be ignored.
- The mode 4 strobe, which must not repeat when the count wraps.
- A zero count, which a design without wrap-around would finish at once.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        M_TERM   = 3'd0,
        M_RETRIG = 3'd1,
        M_RATE   = 3'd2,
        M_SQUARE = 3'd3,
        M_SWSTB  = 3'd4,
        M_HWSTB  = 3'd5
    } pit_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_BOTH = 2'd3
    } pit_acc_e;

    // codes x1x select the periodic modes 2 and 3
    function automatic pit_mode_e mode_of(input logic [2:0] code);
        if (code[1]) return pit_mode_e'({1'b0, code[1:0]});
        return pit_mode_e'(code);
    endfunction

endpackage

// File: rtl/pit_wr_ctrl.sv
module pit_wr_ctrl
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter logic [1:0] SLOT = 2'd0,
    localparam int COUNT_W = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               wr_ctrl_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    output logic [5:0]         cfg_o,
    output pit_mode_e          mode_o,
    output logic [COUNT_W-1:0] cr_o,
    output logic               hold_o,
    output logic               cw_stb_o,
    output logic               cnt_stb_o
);

    typedef struct packed {
        pit_acc_e           acc;
        logic [2:0]         code;
        logic               bcd;
        logic [COUNT_W-1:0] cr;
        logic               msb_next;
        logic               cw_stb;
        logic               cnt_stb;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cw_stb  = 1'b0;
        st_d.cnt_stb = 1'b0;
        if (wr_i) begin
            if (wr_ctrl_i) begin
                if (wr_data_i[7:6] == SLOT && wr_data_i[5:4] != 2'b00) begin
                    st_d.acc      = pit_acc_e'(wr_data_i[5:4]);
                    st_d.code     = wr_data_i[3:1];
                    st_d.bcd      = wr_data_i[0];
                    st_d.msb_next = 1'b0;
                    st_d.cw_stb   = 1'b1;
                end
            end else begin
                unique case (st_q.acc)
                    ACC_LO: begin
                        st_d.cr      = {{BYTE_W{1'b0}}, wr_data_i};
                        st_d.cnt_stb = 1'b1;
                    end
                    ACC_HI: begin
                        st_d.cr      = {wr_data_i, {BYTE_W{1'b0}}};
                        st_d.cnt_stb = 1'b1;
                    end
                    ACC_BOTH: begin
                        if (!st_q.msb_next) begin
                            st_d.cr[BYTE_W-1:0] = wr_data_i;
                            st_d.msb_next       = 1'b1;
                        end else begin
                            st_d.cr[COUNT_W-1:BYTE_W] = wr_data_i;
                            st_d.msb_next             = 1'b0;
                            st_d.cnt_stb              = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{acc: ACC_NONE, code: 3'd0, bcd: 1'b0, cr: '0,
                      msb_next: 1'b0, cw_stb: 1'b0, cnt_stb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o     = {st_q.acc, st_q.code, st_q.bcd};
    assign mode_o    = mode_of(st_q.code);
    assign cr_o      = st_q.cr;
    assign hold_o    = st_q.msb_next;
    assign cw_stb_o  = st_q.cw_stb;
    assign cnt_stb_o = st_q.cnt_stb;

    // R3: first byte of a two-byte count leaves the counter frozen
    p_lsb_then_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wr_ctrl_i && st_q.acc == ACC_BOTH && !st_q.msb_next) |=> hold_o);

endmodule

// File: rtl/pit_gate_trig.sv
module pit_gate_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic consume_i,
    input  logic clr_i,
    output logic trig_o
);

    typedef struct packed {
        logic gate;
        logic pend;
    } trig_state_t;

    trig_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate_i;
        if (clr_i)                      st_d.pend = 1'b0;
        else if (gate_i && !st_q.gate)  st_d.pend = 1'b1;
        else if (consume_i)             st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_o = st_q.pend;

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pit_mode_e          mode_i,
    input  logic [COUNT_W-1:0] cr_i,
    input  logic               cw_stb_i,
    input  logic               cnt_stb_i,
    input  logic               step_i,
    input  logic               gate_i,
    input  logic               trig_i,
    output logic [COUNT_W-1:0] ce_o,
    output logic               out_o,
    output logic               nul_o
);

    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] TWO = COUNT_W'(2);

    typedef struct packed {
        logic [COUNT_W-1:0] ce;
        logic               out;
        logic               nul;
        logic               armed;
        logic               run;
        logic               load_pend;
        logic               fired;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [COUNT_W-1:0] hi_load, lo_load;
    logic               periodic, start;

    assign hi_load  = cr_i + {{(COUNT_W-1){1'b0}}, cr_i[0]};
    assign lo_load  = cr_i - {{(COUNT_W-1){1'b0}}, cr_i[0]};
    assign periodic = (mode_i == M_RATE) || (mode_i == M_SQUARE);
    assign start    = st_q.load_pend || (trig_i && st_q.armed);

    always_comb begin
        st_d = st_q;
        if (cw_stb_i) begin
            st_d.out       = (mode_i != M_TERM);
            st_d.run       = 1'b0;
            st_d.armed     = 1'b0;
            st_d.load_pend = 1'b0;
            st_d.nul       = 1'b1;
            st_d.fired     = 1'b0;
        end else if (cnt_stb_i) begin
            st_d.nul   = 1'b1;
            st_d.armed = 1'b1;
            case (mode_i)
                M_TERM: begin
                    st_d.load_pend = 1'b1;
                    st_d.run       = 1'b0;
                    st_d.out       = 1'b0;
                end
                M_SWSTB: begin
                    st_d.load_pend = 1'b1;
                    st_d.run       = 1'b0;
                    st_d.out       = 1'b1;
                end
                M_RATE, M_SQUARE: begin
                    if (!st_q.run) st_d.load_pend = 1'b1;
                end
                default: ;
            endcase
        end else if (step_i) begin
            case (mode_i)
                M_TERM: begin
                    if (st_q.load_pend) begin
                        st_d.ce        = cr_i;
                        st_d.nul       = 1'b0;
                        st_d.load_pend = 1'b0;
                        st_d.run       = 1'b1;
                        st_d.out       = 1'b0;
                    end else if (st_q.run && gate_i) begin
                        st_d.ce = st_q.ce - ONE;
                        if (st_q.ce == ONE) st_d.out = 1'b1;
                    end
                end
                M_SWSTB: begin
                    if (st_q.load_pend) begin
                        st_d.ce        = cr_i;
                        st_d.nul       = 1'b0;
                        st_d.load_pend = 1'b0;
                        st_d.run       = 1'b1;
                        st_d.out       = 1'b1;
                        st_d.fired     = 1'b0;
                    end else if (st_q.run) begin
                        st_d.out = 1'b1;
                        if (gate_i) begin
                            st_d.ce = st_q.ce - ONE;
                            if (st_q.ce == ONE && !st_q.fired) begin
                                st_d.out   = 1'b0;
                                st_d.fired = 1'b1;
                            end
                        end
                    end
                end
                M_RETRIG: begin
                    if (trig_i && st_q.armed) begin
                        st_d.ce  = cr_i;
                        st_d.nul = 1'b0;
                        st_d.run = 1'b1;
                        st_d.out = 1'b0;
                    end else if (st_q.run) begin
                        st_d.ce = st_q.ce - ONE;
                        if (st_q.ce == ONE) st_d.out = 1'b1;
                    end
                end
                M_HWSTB: begin
                    if (trig_i && st_q.armed) begin
                        st_d.ce    = cr_i;
                        st_d.nul   = 1'b0;
                        st_d.run   = 1'b1;
                        st_d.out   = 1'b1;
                        st_d.fired = 1'b0;
                    end else if (st_q.run) begin
                        st_d.out = 1'b1;
                        st_d.ce  = st_q.ce - ONE;
                        if (st_q.ce == ONE && !st_q.fired) begin
                            st_d.out   = 1'b0;
                            st_d.fired = 1'b1;
                        end
                    end
                end
                M_RATE: begin
                    if (gate_i) begin
                        if (start) begin
                            st_d.ce        = cr_i;
                            st_d.nul       = 1'b0;
                            st_d.run       = 1'b1;
                            st_d.out       = 1'b1;
                            st_d.load_pend = 1'b0;
                        end else if (st_q.run) begin
                            if (st_q.ce == ONE) begin
                                st_d.ce  = cr_i;
                                st_d.nul = 1'b0;
                                st_d.out = 1'b1;
                            end else if (st_q.ce == TWO) begin
                                st_d.ce  = ONE;
                                st_d.out = 1'b0;
                            end else begin
                                st_d.ce = st_q.ce - ONE;
                            end
                        end
                    end
                end
                M_SQUARE: begin
                    if (gate_i) begin
                        if (start) begin
                            st_d.ce        = hi_load;
                            st_d.nul       = 1'b0;
                            st_d.run       = 1'b1;
                            st_d.out       = 1'b1;
                            st_d.load_pend = 1'b0;
                        end else if (st_q.run) begin
                            if (st_q.ce == TWO) begin
                                st_d.out = !st_q.out;
                                st_d.ce  = st_q.out ? lo_load : hi_load;
                                st_d.nul = 1'b0;
                            end else begin
                                st_d.ce = st_q.ce - TWO;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
        if (periodic && !gate_i) st_d.out = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ce: '0, out: 1'b0, nul: 1'b1, armed: 1'b0, run: 1'b0,
                      load_pend: 1'b0, fired: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ce_o  = st_q.ce;
    assign out_o = st_q.out;
    assign nul_o = st_q.nul;

    // R4: a finished count write always leaves the pending flag set
    p_null_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_stb_i |=> nul_o);

    // R12: low gate in a periodic mode raises the line by the next clock
    p_gate_low_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == M_RATE || mode_i == M_SQUARE) && !gate_i) |=> out_o);

    // R6: in mode 0 the line only falls on a new write
    p_term_stays_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_TERM && out_o && !cw_stb_i && !cnt_stb_i) |=> out_o);

    // R9: square-wave counting element stays even while running
    p_square_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_SQUARE && st_q.run && !cw_stb_i) |-> !ce_o[0]);

    // R10: strobe-mode low pulse ends on the following step
    p_strobe_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == M_SWSTB || mode_i == M_HWSTB) && !out_o && step_i) |=> out_o);

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter logic [1:0] SLOT = 2'd0,
    localparam int COUNT_W = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               gate_i,
    input  logic               wr_i,
    input  logic               wr_ctrl_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    output logic               out_o,
    output logic [COUNT_W-1:0] count_o,
    output logic [BYTE_W-1:0]  status_o
);

    logic [5:0]         cfg;
    pit_mode_e          mode;
    logic [COUNT_W-1:0] cr;
    logic               hold, cw_stb, cnt_stb, step, trig, nul;

    assign step = tick_i && !hold && !cw_stb && !cnt_stb;

    pit_wr_ctrl #(.BYTE_W(BYTE_W), .SLOT(SLOT)) i_wr_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_i),
        .wr_ctrl_i (wr_ctrl_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg),
        .mode_o    (mode),
        .cr_o      (cr),
        .hold_o    (hold),
        .cw_stb_o  (cw_stb),
        .cnt_stb_o (cnt_stb)
    );

    pit_gate_trig i_gate_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_i    (gate_i),
        .consume_i (step),
        .clr_i     (cw_stb),
        .trig_o    (trig)
    );

    pit_count_core #(.COUNT_W(COUNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .cr_i      (cr),
        .cw_stb_i  (cw_stb),
        .cnt_stb_i (cnt_stb),
        .step_i    (step),
        .gate_i    (gate_i),
        .trig_i    (trig),
        .ce_o      (count_o),
        .out_o     (out_o),
        .nul_o     (nul)
    );

    assign status_o = BYTE_W'({out_o, nul, cfg});

    // R3: while the high byte is awaited the counting element is frozen
    p_hold_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !cw_stb && !cnt_stb) |=> $stable(count_o));

endmodule

// File: tb/test_pit_counter.sv
module test_pit_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        gate_i = 1'b1;
    logic        wr_i = 1'b0;
    logic        wr_ctrl_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        out_o;
    logic [15:0] count_o;
    logic [7:0]  status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pit_counter i_pit_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .gate_i    (gate_i),
        .wr_i      (wr_i),
        .wr_ctrl_i (wr_ctrl_i),
        .wr_data_i (wr_data_i),
        .out_o     (out_o),
        .count_o   (count_o),
        .status_o  (status_o)
    );

    function automatic int sq_high(int n); return (n + 1) / 2; endfunction
    function automatic int sq_low(int n);  return n / 2;       endfunction
    function automatic int rate_high(int n); return n - 1;     endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wr(bit ctl, logic [7:0] d);
        wr_i = 1'b1; wr_ctrl_i = ctl; wr_data_i = d;
        @(negedge clk);
        wr_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load16(logic [15:0] n);
        wr(1'b0, n[7:0]);
        wr(1'b0, n[15:8]);
    endtask

    task automatic tick1();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    task automatic trigger();
        gate_i = 1'b0;
        @(negedge clk);
        gate_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_len(logic lvl, output int len);
        len = 0;
        while (out_o === lvl && len < 300) begin
            tick1();
            len++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int n, len, k;
        bit low_seen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 out", out_o, 0);
        chk("R1 count", count_o, 0);
        chk("R1 status", status_o, 8'h40);

        // R2 ignored control bytes: access 00, foreign select
        wr(1'b1, 8'h0C);
        chk("R2 access00 ignored", status_o, 8'h40);
        wr(1'b1, 8'h70);
        chk("R2 select ignored", status_o, 8'h40);

        // R2 R5 status echo, bcd bit stored, alias code
        wr(1'b1, 8'h35);
        chk("R5 status mode2 bcd", status_o, 8'hF5);
        chk("R2 out high non-mode0", out_o, 1);
        wr(1'b1, 8'h3C);
        chk("R5 status code110", status_o, 8'hFC);

        // R6 mode 0 with random counts, R12 gate pause, R4 pending flag
        for (int it = 0; it < 3; it++) begin
            n = $urandom_range(3, 30);
            wr(1'b1, 8'h30);
            chk("R2 mode0 out low", out_o, 0);
            load16(16'(n));
            chk("R4 pending after write", status_o[6], 1);
            tick1();
            chk("R4 pending cleared on load", status_o[6], 0);
            chk("R6 load count", count_o, n);
            chk("R6 out low after load", out_o, 0);
            k = 0;
            if (it == 0) begin
                tick1();
                k = 1;
                gate_i = 1'b0;
                ticks(3);
                chk("R12 mode0 gate pause", count_o, n - 1);
                gate_i = 1'b1;
                @(negedge clk);
            end
            ticks(n - 1 - k);
            chk("R6 out low before end", out_o, 0);
            chk("R6 count one", count_o, 1);
            tick1();
            chk("R6 out high at zero", out_o, 1);
        end

        // R3 two-byte hold
        wr(1'b1, 8'h30);
        load16(16'd20);
        ticks(3);
        chk("R3 count before hold", count_o, 18);
        wr(1'b0, 8'h09);
        ticks(3);
        chk("R3 frozen during hold", count_o, 18);
        wr(1'b0, 8'h00);
        tick1();
        chk("R3 new count after msb", count_o, 9);

        // R3 single-byte access schemes
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h05);
        tick1();
        chk("R3 low byte only", count_o, 16'h0005);
        wr(1'b1, 8'h20);
        wr(1'b0, 8'h01);
        tick1();
        chk("R3 high byte only", count_o, 16'h0100);

        // R8 mode 2, one run through the alias code 110
        for (int it = 0; it < 3; it++) begin
            n = (it == 2) ? 4 : $urandom_range(2, 15);
            wr(1'b1, (it == 2) ? 8'h3C : 8'h34);
            load16(16'(n));
            tick1();
            chk("R8 load out high", out_o, 1);
            chk("R8 load count", count_o, n);
            run_len(1'b1, len);
            chk("R8 high strobes", len, rate_high(n));
            chk("R8 count at low", count_o, 1);
            tick1();
            chk("R8 reload out", out_o, 1);
            chk("R8 reload count", count_o, n);
            run_len(1'b1, len);
            chk("R8 second period", len, rate_high(n));
            gate_i = 1'b0;
            @(negedge clk);
            chk("R12 mode2 gate forces high", out_o, 1);
            tick1();
            chk("R12 mode2 paused", count_o, 1);
            gate_i = 1'b1;
            @(negedge clk);
            tick1();
            chk("R12 mode2 reload on rise", count_o, n);
        end

        // R9 mode 3 odd and even counts
        for (int it = 0; it < 4; it++) begin
            n = $urandom_range(2, 21);
            if (it == 0) n = n | 1;
            if (it == 1) n = (n & ~1) | 2;
            if (it == 2) n = 3;
            wr(1'b1, 8'h36);
            load16(16'(n));
            tick1();
            chk("R9 load out high", out_o, 1);
            run_len(1'b1, len);
            chk("R9 high phase", len, sq_high(n));
            run_len(1'b0, len);
            chk("R9 low phase", len, sq_low(n));
            run_len(1'b1, len);
            chk("R9 high phase repeat", len, sq_high(n));
            gate_i = 1'b0;
            @(negedge clk);
            chk("R12 mode3 gate forces high", out_o, 1);
            gate_i = 1'b1;
            @(negedge clk);
            tick1();
            chk("R12 mode3 reload on rise", count_o, n + (n & 1));
        end

        // R7 mode 1 one-shot with retrigger
        n = $urandom_range(5, 14);
        wr(1'b1, 8'h32);
        load16(16'(n));
        chk("R7 idle high", out_o, 1);
        ticks(2);
        chk("R4 pending until trigger", status_o[6], 1);
        trigger();
        tick1();
        chk("R7 out low on trigger", out_o, 0);
        chk("R7 count loaded", count_o, n);
        chk("R4 pending cleared", status_o[6], 0);
        ticks(2);
        chk("R7 counting", count_o, n - 2);
        trigger();
        tick1();
        chk("R7 retrigger reload", count_o, n);
        ticks(n - 1);
        chk("R7 still low", out_o, 0);
        tick1();
        chk("R7 high after N", out_o, 1);

        // R10 mode 4
        n = $urandom_range(3, 12);
        wr(1'b1, 8'h38);
        load16(16'(n));
        tick1();
        chk("R10 load count", count_o, n);
        ticks(n - 1);
        chk("R10 high before strobe", out_o, 1);
        tick1();
        chk("R10 strobe low", out_o, 0);
        tick1();
        chk("R10 strobe one step", out_o, 1);
        low_seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick1();
            if (out_o !== 1'b1) low_seen = 1'b1;
        end
        chk("R10 no second strobe", low_seen, 0);

        // R11 mode 5
        n = $urandom_range(3, 12);
        wr(1'b1, 8'h3A);
        load16(16'(n));
        ticks(2);
        chk("R11 waits for gate", status_o[6], 1);
        chk("R11 idle high", out_o, 1);
        trigger();
        tick1();
        chk("R11 load on rise", count_o, n);
        ticks(n - 1);
        chk("R11 high before strobe", out_o, 1);
        tick1();
        chk("R11 strobe low", out_o, 0);
        tick1();
        chk("R11 strobe one step", out_o, 1);

        // R13 zero count means 65536 in mode 0
        wr(1'b1, 8'h30);
        load16(16'h0000);
        tick1();
        chk("R13 load zero", count_o, 0);
        tick_i = 1'b1;
        len = 0;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            len++;
            if (out_o === 1'b1) break;
        end
        tick_i = 1'b0;
        chk("R13 full span", len, 65536);

        finish_run();
    end

endmodule